// File: doc/BRIEF.md
# Asynchronous ROM Read Sequencer

This block sits on the host side of a byte-wide asynchronous ROM that has separate active-low chip-select and output-gate pins. A request carries an address with a valid/ready handshake. The block turns each request into pin activity. It drives the address and pulls the chip select low. It holds the output gate back by the slack the part allows, waits out the address-access and gate-access delays, and then captures the byte. The byte comes back on a one-cycle response strobe.

All pin timing is counted in clock cycles. The counts come from nanosecond parameters and a clock-period parameter. Each delay is rounded up to whole cycles, and a margin is added for synchronisation. The access delay and the gate delay are tracked by separate counters, and the capture waits for both. After the capture, the output gate rises at once and a third count, the float time, runs. A new request is not accepted until that count has run out, so the ROM has released the shared data lines before anything else can drive them. A parameter keeps the chip select low when reads arrive back to back. In that case only the address and the gate are issued again.

Top module: `rom_rd_sequencer`

## Requirements
- R1: After synchronous reset, `rom_ce_n` and `rom_oe_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: When `req_valid` and `req_ready` are both 1 at a rising edge, that edge loads `rom_addr` with `req_addr` and drives `rom_ce_n` to 0. Both stay unchanged until the capture edge.
- R3: `rom_oe_n` goes to 0 exactly DEFER+1 edges after the accepting edge. DEFER is floor((T_ACC_NS - T_OE_NS) / CLK_PERIOD_NS), or 0 if that difference is not positive. `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R4: Each delay in cycles is ceil(ns / CLK_PERIOD_NS) + SYNC_MARGIN. This gives ACC for address access, OEC for gate access and FLT for float.
- R5: The capture edge lies max(ACC, DEFER+1+OEC)+1 edges after the accepting edge. At that edge `rsp_data` takes the value on `rom_dq` and `rsp_valid` is 1 for exactly one cycle.
- R6: At the capture edge `rom_oe_n` returns to 1. With CE_HOLD=0, `rom_ce_n` returns to 1 at the same edge.
- R7: `req_ready` is 0 from the capture edge through FLT more edges. It returns to 1 at the edge FLT+1 after capture.
- R8: A `req_valid` presented while `req_ready` is 0 has no effect. `rom_addr` keeps the accepted address and no extra response appears.
- R9: With CE_HOLD=1, `rom_ce_n` stays 0 when the next request is accepted in the first ready cycle. It goes to 1 after any edge at which the block is ready and no request is present.
- R10: Every accepted request restarts the address-access count. Back-to-back reads to different addresses each take the full latency of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address to read |
| rsp_valid | output | 1 | One-cycle strobe marking captured data |
| rsp_data | output | DATA_W | Captured byte |
| rom_addr | output | ADDR_W | Address lines to the ROM |
| rom_ce_n | output | 1 | Active-low chip select |
| rom_oe_n | output | 1 | Active-low output gate |
| rom_dq | input | DATA_W | Data lines from the ROM |

## Verification
In hold mode, two things can fall in the same cycle. One is the choice to release the chip select. The other is the acceptance of the next request in the first cycle the block is ready again. The bench provokes this by presenting every read of a full address sweep at the very first sample where ready is seen high. It judges the outcome two ways. The hold instance must keep its chip select low throughout, and every read must still show the full latency. Separate reads with a one-cycle idle gap take the other branch, where the chip select must rise. A timing-aware ROM model returns corrupted data when either access window is short. A capture placed too early therefore also shows up as a data mismatch.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  localparam int TMR_ACC   = 0;
  localparam int TMR_DEFER = 1;
  localparam int TMR_OE    = 2;
  localparam int TMR_FLT   = 3;
  localparam int NUM_TMR   = 4;

  // Round a nanosecond delay up to whole cycles and add the sync margin.
  function automatic int ns_to_cycles(input int ns, input int period, input int margin);
    return (ns + period - 1) / period + margin;
  endfunction

  // Cycles the output gate may be held back without stretching the access.
  function automatic int defer_cycles(input int acc_ns, input int oe_ns, input int period);
    return (acc_ns > oe_ns) ? (acc_ns - oe_ns) / period : 0;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_dly_cnt.sv
module rom_rd_dly_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= init;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R4: a running count only moves toward expiry
  a_r4_count_moves_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !done) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/rom_rd_ctrl_fsm.sv
module rom_rd_ctrl_fsm #(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CE_HOLD = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_data,
  output logic [ADDR_W-1:0]              rom_addr,
  output logic                           rom_ce_n,
  output logic                           rom_oe_n,
  input  logic [DATA_W-1:0]              rom_dq,
  output logic [rom_rd_pkg::NUM_TMR-1:0] tmr_load,
  input  logic [rom_rd_pkg::NUM_TMR-1:0] tmr_done
);

  rom_rd_pkg::rd_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q;
  logic              oe_n_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic accept;
  logic oe_fire;
  logic capture;
  logic ce_release;

  // Event decode
  always_comb begin
    accept  = (state_q == rom_rd_pkg::ST_IDLE) && req_valid;
    oe_fire = (state_q == rom_rd_pkg::ST_ACCESS) && oe_n_q &&
              tmr_done[rom_rd_pkg::TMR_DEFER];
    capture = (state_q == rom_rd_pkg::ST_ACCESS) && !oe_n_q &&
              tmr_done[rom_rd_pkg::TMR_OE] && tmr_done[rom_rd_pkg::TMR_ACC];
  end

  // Timer starts
  always_comb begin
    tmr_load = '0;
    tmr_load[rom_rd_pkg::TMR_ACC]   = accept;
    tmr_load[rom_rd_pkg::TMR_DEFER] = accept;
    tmr_load[rom_rd_pkg::TMR_OE]    = oe_fire;
    tmr_load[rom_rd_pkg::TMR_FLT]   = capture;
  end

  // Chip-select release policy chosen by parameter
  generate
    if (CE_HOLD != 0) begin : g_ce_hold
      assign ce_release = (state_q == rom_rd_pkg::ST_IDLE) && !req_valid;
    end else begin : g_ce_drop
      assign ce_release = capture;
    end
  endgenerate

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      rom_rd_pkg::ST_IDLE:   if (accept)  state_d = rom_rd_pkg::ST_ACCESS;
      rom_rd_pkg::ST_ACCESS: if (capture) state_d = rom_rd_pkg::ST_FLOAT;
      rom_rd_pkg::ST_FLOAT:  if (tmr_done[rom_rd_pkg::TMR_FLT]) state_d = rom_rd_pkg::ST_IDLE;
      default:               state_d = rom_rd_pkg::ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= rom_rd_pkg::ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Address register: loaded only on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  // Pin controls
  always_ff @(posedge clk) begin
    if (rst) begin
      ce_n_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else begin
      if (accept) begin
        ce_n_q <= 1'b0;
      end else if (ce_release) begin
        ce_n_q <= 1'b1;
      end
      if (oe_fire) begin
        oe_n_q <= 1'b0;
      end else if (capture || accept) begin
        oe_n_q <= 1'b1;
      end
    end
  end

  // Response capture
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= capture;
      if (capture) begin
        rsp_data_q <= rom_dq;
      end
    end
  end

  assign req_ready = (state_q == rom_rd_pkg::ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rom_addr  = addr_q;
  assign rom_ce_n  = ce_n_q;
  assign rom_oe_n  = oe_n_q;

  // R3: the output gate is only open while the chip is selected
  a_r3_oe_needs_ce: assert property (@(posedge clk) disable iff (rst)
    !oe_n_q |-> !ce_n_q);

  // R3: the gate opens only from inside an access
  a_r3_oe_opens_in_access: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n_q) |-> $past(state_q == rom_rd_pkg::ST_ACCESS));

  // R5: response strobe lasts one cycle
  a_r5_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |=> !rsp_valid_q);

  // R5: capture never precedes address-access expiry
  a_r5_rsp_after_acc: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> $past(tmr_done[rom_rd_pkg::TMR_ACC]));

  // R6: the gate is closed when data is presented
  a_r6_gate_closed_on_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_q |-> oe_n_q);

  // R7: closing the gate is followed by a float gap, not readiness
  a_r7_gap_before_ready: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n_q) |-> !req_ready);

  // R8: a busy sequencer keeps its address
  a_r8_busy_holds_addr: assert property (@(posedge clk) disable iff (rst)
    (state_q != rom_rd_pkg::ST_IDLE) |=> $stable(addr_q));

endmodule

// File: rtl/rom_rd_sequencer.sv
module rom_rd_sequencer #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ACC_NS      = 55,
  parameter int T_OE_NS       = 35,
  parameter int T_FLOAT_NS    = 25,
  parameter int SYNC_MARGIN   = 1,
  parameter int CE_HOLD       = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  input  logic [DATA_W-1:0] rom_dq
);

  localparam int ACC_CYC   = rom_rd_pkg::ns_to_cycles(T_ACC_NS,   CLK_PERIOD_NS, SYNC_MARGIN);
  localparam int OE_CYC    = rom_rd_pkg::ns_to_cycles(T_OE_NS,    CLK_PERIOD_NS, SYNC_MARGIN);
  localparam int FLT_CYC   = rom_rd_pkg::ns_to_cycles(T_FLOAT_NS, CLK_PERIOD_NS, SYNC_MARGIN);
  localparam int DEFER_CYC = rom_rd_pkg::defer_cycles(T_ACC_NS, T_OE_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = rom_rd_pkg::max_of(rom_rd_pkg::max_of(ACC_CYC, OE_CYC),
                                                rom_rd_pkg::max_of(FLT_CYC, DEFER_CYC));
  localparam int CNT_W     = rom_rd_pkg::max_of($clog2(MAX_CYC + 1), 1);
  localparam int NT        = rom_rd_pkg::NUM_TMR;

  logic [NT-1:0]            tmr_load;
  logic [NT-1:0]            tmr_done;
  logic [NT-1:0][CNT_W-1:0] tmr_init;

  assign tmr_init[rom_rd_pkg::TMR_ACC]   = CNT_W'(ACC_CYC);
  assign tmr_init[rom_rd_pkg::TMR_DEFER] = CNT_W'(DEFER_CYC);
  assign tmr_init[rom_rd_pkg::TMR_OE]    = CNT_W'(OE_CYC);
  assign tmr_init[rom_rd_pkg::TMR_FLT]   = CNT_W'(FLT_CYC);

  generate
    for (genvar g = 0; g < NT; g++) begin : g_tmr
      rom_rd_dly_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load[g]),
        .init (tmr_init[g]),
        .done (tmr_done[g])
      );
    end
  endgenerate

  rom_rd_ctrl_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CE_HOLD (CE_HOLD)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rom_addr  (rom_addr),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .rom_dq    (rom_dq),
    .tmr_load  (tmr_load),
    .tmr_done  (tmr_done)
  );

endmodule

// File: tb/rom_rd_sequencer_test.sv
module rom_timing_model #(
  parameter int AW = 6,
  parameter int PERIOD = 10,
  parameter int TA = 55,
  parameter int TO = 35
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  output logic [7:0]    dq
);
  int addr_age = 0;
  int oe_age = 0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [7:0] content(input logic [AW-1:0] a);
    return 8'((int'(a) * 37 + 5) & 255);
  endfunction

  initial dq = 8'h00;

  always @(negedge clk) begin
    if (ce_n || addr != prev_addr) addr_age = 0; else addr_age++;
    if (ce_n || oe_n) oe_age = 0; else oe_age++;
    prev_addr = addr;
    if (!ce_n && !oe_n && addr_age * PERIOD >= TA && oe_age * PERIOD >= TO)
      dq = content(addr);
    else
      dq = ~content(addr);
  end
endmodule

module rom_rd_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int TA = 55;
  localparam int TO = 35;
  localparam int TF = 25;
  localparam int MARGIN = 1;
  localparam int ACC = (TA + CLK_PERIOD - 1) / CLK_PERIOD + MARGIN;
  localparam int OEC = (TO + CLK_PERIOD - 1) / CLK_PERIOD + MARGIN;
  localparam int FLT = (TF + CLK_PERIOD - 1) / CLK_PERIOD + MARGIN;
  localparam int DEFER = (TA - TO) / CLK_PERIOD;
  localparam int CAP = ((ACC > DEFER + 1 + OEC) ? ACC : DEFER + 1 + OEC) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;

  logic req_ready, rsp_valid, rom_ce_n, rom_oe_n;
  logic [7:0] rsp_data, rom_dq;
  logic [AW-1:0] rom_addr;
  logic req_ready_h, rsp_valid_h, rom_ce_n_h, rom_oe_n_h;
  logic [7:0] rsp_data_h, rom_dq_h;
  logic [AW-1:0] rom_addr_h;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rom_rd_sequencer #(.ADDR_W(AW), .DATA_W(8), .CLK_PERIOD_NS(CLK_PERIOD), .T_ACC_NS(TA),
    .T_OE_NS(TO), .T_FLOAT_NS(TF), .SYNC_MARGIN(MARGIN), .CE_HOLD(0)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_dq(rom_dq));

  rom_rd_sequencer #(.ADDR_W(AW), .DATA_W(8), .CLK_PERIOD_NS(CLK_PERIOD), .T_ACC_NS(TA),
    .T_OE_NS(TO), .T_FLOAT_NS(TF), .SYNC_MARGIN(MARGIN), .CE_HOLD(1)) uut_hold (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready_h), .req_addr(req_addr),
    .rsp_valid(rsp_valid_h), .rsp_data(rsp_data_h), .rom_addr(rom_addr_h), .rom_ce_n(rom_ce_n_h),
    .rom_oe_n(rom_oe_n_h), .rom_dq(rom_dq_h));

  rom_timing_model #(.AW(AW), .PERIOD(CLK_PERIOD), .TA(TA), .TO(TO)) u_rom (
    .clk(clk), .addr(rom_addr), .ce_n(rom_ce_n), .oe_n(rom_oe_n), .dq(rom_dq));
  rom_timing_model #(.AW(AW), .PERIOD(CLK_PERIOD), .TA(TA), .TO(TO)) u_rom_h (
    .clk(clk), .addr(rom_addr_h), .ce_n(rom_ce_n_h), .oe_n(rom_oe_n_h), .dq(rom_dq_h));

  function automatic logic [7:0] expect_byte(input logic [AW-1:0] a);
    return 8'((int'(a) * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // One read, entered at a negedge with ready high; leaves at the negedge where ready is high again.
  task automatic do_read(input logic [AW-1:0] a, input bit back_to_back);
    int k;
    int gap;
    int extra;
    bit oe_ok;
    bit addr_ok;
    bit ce_ok;
    bit hold_ok;
    req_addr = a;
    req_valid = 1'b1;
    @(negedge clk);
    // busy from here: offer a different address that must be ignored (R8)
    req_addr = ~a;
    k = 0;
    oe_ok = 1'b1; addr_ok = 1'b1; ce_ok = 1'b1; hold_ok = 1'b1;
    while (!rsp_valid && k < 4 * CAP) begin
      if (rom_oe_n != (k < DEFER + 1)) oe_ok = 1'b0;
      if (rom_addr != a) addr_ok = 1'b0;
      if (rom_ce_n != 1'b0) ce_ok = 1'b0;
      if (rom_ce_n_h != 1'b0) hold_ok = 1'b0;
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    chk(oe_ok, "R3 gate schedule", int'(rom_oe_n), int'(k < DEFER + 1));
    chk(addr_ok && rom_addr == a, "R2/R8 address held", int'(rom_addr), int'(a));
    chk(ce_ok, "R2 chip select low in access", int'(rom_ce_n), 0);
    chk(k == CAP, "R5/R10 capture latency", k, CAP);
    chk(rsp_data == expect_byte(a), "R5 captured byte", int'(rsp_data), int'(expect_byte(a)));
    chk(rsp_data_h == expect_byte(a), "R5 captured byte hold", int'(rsp_data_h), int'(expect_byte(a)));
    chk(rom_oe_n == 1'b1, "R6 gate closed at capture", int'(rom_oe_n), 1);
    chk(rom_ce_n == 1'b1, "R6 chip select released", int'(rom_ce_n), 1);
    if (back_to_back)
      chk(hold_ok && rom_ce_n_h == 1'b0, "R9 hold keeps select", int'(rom_ce_n_h), 0);
    gap = 0;
    extra = 0;
    while (!req_ready && gap < 4 * FLT + 4) begin
      gap++;
      @(negedge clk);
      if (rsp_valid) extra++;
    end
    chk(gap == FLT + 1, "R7 float gap", gap, FLT + 1);
    chk(extra == 0, "R8 no extra response", extra, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rom_ce_n == 1'b1 && rom_oe_n == 1'b1, "R1 pins idle in reset",
        int'({rom_ce_n, rom_oe_n}), 3);
    rst = 1'b0;
    @(negedge clk);
    chk(rom_ce_n == 1'b1 && rom_oe_n == 1'b1, "R1 pins idle", int'({rom_ce_n, rom_oe_n}), 3);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);
    chk(ACC == 7 && OEC == 5 && FLT == 4, "R4 rounded counts", ACC * 100 + OEC * 10 + FLT, 754);

    // Back-to-back sweep of every address (R9, R10)
    do_read('0, 1'b0);
    for (int i = 1; i < (1 << AW); i++) do_read(AW'(i), 1'b1);

    // Reads with an idle cycle between them (R9 release path)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(rom_ce_n_h == 1'b1, "R9 idle releases select", int'(rom_ce_n_h), 1);
      chk(req_ready == 1'b1, "R8 idle stays ready", int'(req_ready), 1);
      do_read(AW'((1 << AW) - 1 - 5 * i), 1'b0);
    end
    finish_run();
  end
endmodule